// File: doc/BRIEF.md
# Interlocked Two-Phase Memory Read Engine

This block carries out a single-word read from a small memory array to a requesting device over a set of shared lines. The two parties are not assumed to share a clock. They coordinate only through level changes on three control wires: a read request raised by the device, a data-ready strobe raised by the memory, and one acknowledge wire that either party may raise. The same lines carry the address out to the memory and then carry the data word back to the device, so each read is two four-phase exchanges that must follow one another in order.

The device side takes commands on a valid/ready stream and returns each word on a second valid/ready stream. A command is taken only when `cmd_valid` and `cmd_ready` are high at the same clock edge. `cmd_ready` stays low from that edge until the response has been taken. A response is offered by holding `rsp_valid` high, and it is taken at the first edge where `rsp_ready` is high. The device may stall it for any number of cycles, and the word stays constant while it waits. The memory side holds a table that is loaded at reset. It waits a programmable number of cycles, taken from `mem_latency`, before it returns the word. Each side passes the control wires it receives through two flip-flops before it acts on them. The shared lines and the drive enable of each side are also brought out as probe outputs.

Top module: `rh_read_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` is 0, and the request, data-ready and acknowledge lines are all low. Neither side drives the shared lines.
- R2: An address exchange starts with the device raising the request line while it drives the zero-extended address on the shared lines. While the request is high and the acknowledge is low, the device keeps driving that address. The device lets go of the lines and drops the request only after it sees the acknowledge.
- R3: The device and the memory never drive the shared lines in the same cycle.
- R4: While the data-ready line is high, the memory drives the shared lines with the requested word. It drops data-ready and releases the lines only after it sees the acknowledge.
- R5: The request and data-ready lines are never high together, and a new request rises only while the acknowledge line is low.
- R6: The returned word for address a equals the low DATA_W bits of (a × 0x1357) XOR 0xA5C3. This is the table content loaded at reset.
- R7: `mem_latency` (0 to 15) is sampled when the address exchange ends. Each unit adds exactly one cycle between acceptance of a command and `rsp_valid`.
- R8: A command is taken only when `cmd_valid` and `cmd_ready` are both high at a clock edge. `cmd_ready` stays low from that edge until the response has been taken.
- R9: Once `rsp_valid` is high, it stays high with `rsp_data` unchanged until the cycle in which `rsp_ready` is high. It is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low reset; it also reloads the table |
| cmd_valid | input | 1 | A read command is offered |
| cmd_ready | output | 1 | The device side can take a command |
| cmd_addr | input | ADDR_W (4) | Address to read |
| rsp_valid | output | 1 | A returned word is offered |
| rsp_ready | input | 1 | The consumer takes the word |
| rsp_data | output | DATA_W (16) | Returned word |
| mem_latency | input | LAT_W (4) | Memory delay before data-ready, in cycles |
| line_data | output | BUS_W (16) | Probe: resolved shared lines |
| line_readreq | output | 1 | Probe: request line |
| line_datardy | output | 1 | Probe: data-ready line |
| line_ack | output | 1 | Probe: shared acknowledge line |
| line_req_drive | output | 1 | Probe: device drive enable |
| line_mem_drive | output | 1 | Probe: memory drive enable |

## Verification
Two events can fall in the same cycle. One is a consumer taking a finished response. The other is a new command arriving for the next read. To provoke this, the bench raises `rsp_ready` and `cmd_valid` carrying the next address at the same clock edge. `cmd_ready` is still low at that edge, so the command must wait one cycle and then be taken exactly once. The bench judges this in three ways: `rsp_valid` must fall, `cmd_ready` must return, and the following read must deliver the word for the new address with the expected latency. A probe monitor watches every cycle for both drivers enabled at once and for the strobes overlapping.

// File: rtl/rh_pkg.sv
package rh_pkg;

  typedef enum logic [2:0] {
    RQ_IDLE, RQ_ADDR, RQ_AREL, RQ_DWAIT, RQ_DACK, RQ_DEND, RQ_RSP
  } rq_state_e;

  typedef enum logic [2:0] {
    MS_IDLE, MS_AACK, MS_AEND, MS_WAIT, MS_DRDY, MS_DREL
  } ms_state_e;

endpackage

// File: rtl/rh_sync.sv
module rh_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/rh_requester.sv
module rh_requester
  import rh_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  input  logic          ack_in,
  input  logic          drdy_in,
  input  logic [DW-1:0] bus_in,
  output logic          rreq_out,
  output logic          ack_out,
  output logic          drv_en,
  output logic [BW-1:0] drv_val
);
  rq_state_e     state;
  logic          ack_s, drdy_s;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  rh_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ack_in, drdy_in}), .q({ack_s, drdy_s})
  );

  assign cmd_ready = (state == RQ_IDLE);
  assign rsp_valid = (state == RQ_RSP);
  assign rsp_data  = data_q;
  assign drv_val   = BW'(addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RQ_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      rreq_out <= 1'b0;
      ack_out  <= 1'b0;
      drv_en   <= 1'b0;
    end else begin
      unique case (state)
        RQ_IDLE: if (cmd_valid) begin
          addr_q   <= cmd_addr;
          drv_en   <= 1'b1;
          rreq_out <= 1'b1;
          state    <= RQ_ADDR;
        end
        RQ_ADDR: if (ack_s) begin
          rreq_out <= 1'b0;
          drv_en   <= 1'b0;
          state    <= RQ_AREL;
        end
        RQ_AREL: if (!ack_s) state <= RQ_DWAIT;
        RQ_DWAIT: if (drdy_s) begin
          data_q  <= bus_in;
          ack_out <= 1'b1;
          state   <= RQ_DACK;
        end
        RQ_DACK: if (!drdy_s) begin
          ack_out <= 1'b0;
          state   <= RQ_DEND;
        end
        // own acknowledge must be seen low before a new request may rise
        RQ_DEND: if (!ack_s) state <= RQ_RSP;
        RQ_RSP:  if (rsp_ready) state <= RQ_IDLE;
        default: state <= RQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rh_responder.sv
module rh_responder
  import rh_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int BW = 16,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] latency,
  input  logic          rreq_in,
  input  logic          ack_in,
  input  logic [AW-1:0] addr_in,
  output logic          ack_out,
  output logic          drdy_out,
  output logic          drv_en,
  output logic [BW-1:0] drv_val
);
  localparam int DEPTH = 1 << AW;

  ms_state_e     state;
  logic          rreq_s, ack_s;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] cnt;
  logic [DW-1:0] dval;
  logic [DW-1:0] table_q [DEPTH];

  function automatic logic [DW-1:0] init_word(input int unsigned i);
    logic [31:0] p;
    p = i * 32'h1357;
    return DW'(p) ^ DW'(32'hA5C3);
  endfunction

  rh_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({rreq_in, ack_in}), .q({rreq_s, ack_s})
  );

  assign drv_val = BW'(dval);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) table_q[i] <= init_word(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= MS_IDLE;
      addr_q   <= '0;
      cnt      <= '0;
      dval     <= '0;
      ack_out  <= 1'b0;
      drdy_out <= 1'b0;
      drv_en   <= 1'b0;
    end else begin
      unique case (state)
        MS_IDLE: if (rreq_s) begin
          addr_q  <= addr_in;
          ack_out <= 1'b1;
          state   <= MS_AACK;
        end
        MS_AACK: if (!rreq_s) begin
          ack_out <= 1'b0;
          state   <= MS_AEND;
        end
        // wait for own acknowledge to clear through the synchronizer
        MS_AEND: if (!ack_s) begin
          cnt   <= latency;
          state <= MS_WAIT;
        end
        MS_WAIT: begin
          if (cnt == '0) begin
            dval     <= table_q[addr_q];
            drv_en   <= 1'b1;
            drdy_out <= 1'b1;
            state    <= MS_DRDY;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        MS_DRDY: if (ack_s) begin
          drv_en   <= 1'b0;
          drdy_out <= 1'b0;
          state    <= MS_DREL;
        end
        MS_DREL: if (!ack_s) state <= MS_IDLE;
        default: state <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rh_read_engine.sv
module rh_read_engine #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int LAT_W  = 4,
  localparam int BUS_W = (DATA_W > ADDR_W) ? DATA_W : ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [LAT_W-1:0]  mem_latency,
  output logic [BUS_W-1:0]  line_data,
  output logic              line_readreq,
  output logic              line_datardy,
  output logic              line_ack,
  output logic              line_req_drive,
  output logic              line_mem_drive
);
  logic             rreq, drdy, ack_dev, ack_mem;
  logic             dev_oe, mem_oe;
  logic [BUS_W-1:0] dev_val, mem_val, lines;

  // tri-state lines resolved as a gated wired-OR of the two drivers
  assign lines = (dev_oe ? dev_val : '0) | (mem_oe ? mem_val : '0);
  assign line_ack = ack_dev | ack_mem;

  rh_requester #(.AW(ADDR_W), .DW(DATA_W), .BW(BUS_W)) u_dev (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ack_in(line_ack), .drdy_in(drdy), .bus_in(lines[DATA_W-1:0]),
    .rreq_out(rreq), .ack_out(ack_dev), .drv_en(dev_oe), .drv_val(dev_val)
  );

  rh_responder #(.AW(ADDR_W), .DW(DATA_W), .BW(BUS_W), .LW(LAT_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .latency(mem_latency),
    .rreq_in(rreq), .ack_in(line_ack), .addr_in(lines[ADDR_W-1:0]),
    .ack_out(ack_mem), .drdy_out(drdy), .drv_en(mem_oe), .drv_val(mem_val)
  );

  assign line_data      = lines;
  assign line_readreq   = rreq;
  assign line_datardy   = drdy;
  assign line_req_drive = dev_oe;
  assign line_mem_drive = mem_oe;
endmodule

// File: rtl/rh_read_checker.sv
module rh_read_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              line_readreq,
  input logic              line_datardy,
  input logic              line_ack,
  input logic              line_req_drive,
  input logic              line_mem_drive
);
  assert_no_contention_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_req_drive && line_mem_drive));

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_readreq && line_datardy));

  assert_req_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_readreq) |-> !line_ack);

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_readreq && !line_ack) |-> line_req_drive);

  assert_data_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    line_datardy |-> line_mem_drive);

  assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind rh_read_engine rh_read_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .line_readreq(line_readreq),
  .line_datardy(line_datardy), .line_ack(line_ack),
  .line_req_drive(line_req_drive), .line_mem_drive(line_mem_drive)
);

// File: tb/rh_read_engine_tb.sv
module rh_read_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_data;
  logic [3:0]  mem_latency = '0;
  logic [15:0] line_data;
  logic        line_readreq, line_datardy, line_ack, line_req_drive, line_mem_drive;

  int checks = 0, fails = 0;
  int base_cyc = -1;
  int v2 = 0, v3 = 0, v4 = 0, v5 = 0;
  logic [3:0]  exp_addr = '0;
  logic [15:0] exp_data = '0;

  always #5 clk = ~clk;

  rh_read_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .mem_latency(mem_latency), .line_data(line_data),
    .line_readreq(line_readreq), .line_datardy(line_datardy), .line_ack(line_ack),
    .line_req_drive(line_req_drive), .line_mem_drive(line_mem_drive)
  );

  function automatic logic [15:0] exp_word(input logic [3:0] a);
    logic [31:0] p;
    p = 32'(a) * 32'h1357;
    return p[15:0] ^ 16'hA5C3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // line monitor, sampled away from the active edge
  always @(negedge clk) if (rst_n) begin
    if (line_req_drive && line_mem_drive) v3++;
    if (line_readreq && line_datardy) v5++;
    if (line_readreq && !line_ack && (!line_req_drive || line_data != 16'(exp_addr))) v2++;
    if (line_datardy && (!line_mem_drive || line_data != exp_data)) v4++;
  end

  task automatic run_read(input logic [3:0] a, input logic [3:0] l, input int stall,
                          input bit chain, input logic [3:0] na, input logic [3:0] nl);
    int n;
    exp_addr = a; exp_data = exp_word(a);
    cmd_addr = a; mem_latency = l; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_ready == 1'b0, "R8 busy after accept", cmd_ready, 0);
    n = 1;
    while (!rsp_valid) begin @(negedge clk); n++; end
    check(rsp_data == exp_word(a), "R6 data (via R2 R4 exchanges)", rsp_data, exp_word(a));
    if (base_cyc < 0) base_cyc = n - int'(l);
    else check(n == base_cyc + int'(l), "R7 latency cycles", n, base_cyc + int'(l));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(rsp_valid && rsp_data == exp_word(a), "R9 held under stall", rsp_data, exp_word(a));
      check(cmd_ready == 1'b0, "R8 busy while offered", cmd_ready, 0);
    end
    rsp_ready = 1'b1;
    if (chain) begin cmd_addr = na; mem_latency = nl; cmd_valid = 1'b1; end
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid == 1'b0, "R9 taken on ready", rsp_valid, 0);
    check(cmd_ready == 1'b1, "R8 ready after take", cmd_ready, 1);
    check(v2 == 0, "R2 address exchange", v2, 0);
    check(v3 == 0, "R3 drive contention", v3, 0);
    check(v4 == 0, "R4 data exchange", v4, 0);
    check(v5 == 0, "R5 strobe overlap", v5, 0);
    v2 = 0; v3 = 0; v4 = 0; v5 = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !rsp_valid, "R1 reset stream state", {cmd_ready, rsp_valid}, 2);
    check(!line_readreq && !line_datardy && !line_ack, "R1 reset strobes",
          {line_readreq, line_datardy, line_ack}, 0);
    check(!line_req_drive && !line_mem_drive, "R1 reset drivers",
          {line_req_drive, line_mem_drive}, 0);
    // directed corners: latency extremes, address extremes, stall, chaining
    run_read(4'd0,  4'd0,  0, 1'b0, 4'd0, 4'd0);
    run_read(4'd15, 4'd15, 3, 1'b0, 4'd0, 4'd0);
    run_read(4'd0,  4'd15, 0, 1'b1, 4'd15, 4'd0);
    run_read(4'd15, 4'd0,  5, 1'b0, 4'd0, 4'd0);
    begin
      logic [3:0] a, l;
      a = 4'($urandom_range(0, 15));
      l = 4'($urandom_range(0, 15));
      for (int i = 0; i < 60; i++) begin
        logic [3:0] na, nl;
        bit ch;
        na = 4'($urandom_range(0, 15));
        nl = 4'($urandom_range(0, 15));
        ch = ($urandom_range(0, 1) == 1);
        run_read(a, l, $urandom_range(0, 3), ch, na, nl);
        a = na; l = nl;
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule